// File: doc/BRIEF.md
# Multi-Channel Memory Copy Engine

This block copies blocks of data from one address range to another on its own, so a processor does not have to move each element. It has seven channels. Each channel holds a source address, a destination address, an element count, an element size, separate byte steps for source and destination, a start condition and a set of mode bits. A channel starts when its chosen hardware request line pulses, when software writes its start register, or when another chosen channel finishes its block.

Each element goes through one single-beat memory port in two steps: a read from the source, then a write to the destination. Between elements the engine picks which channel runs next. A channel with the raise-priority bit set beats every channel without it. Within the same class, the lower channel index wins. A more urgent channel therefore takes the port from a running one at the next element boundary. The displaced channel later continues from the address and count it had reached.

Channels 0 to 2 can run in repeat mode, where they reload their starting values after each block. Channels 3 to 6 always disable themselves when their block ends. Per-channel sticky flags report block completion and an earlier mid-block point. The early point lets software refill one half of a double buffer while the engine fills the other half.

Top module: `dma_engine`

## Requirements
- R1: After reset, `mem_valid`, every `sts_done`/`sts_early` bit and both interrupt outputs are 0.
- R2: Each element is one read beat (`mem_we`=0) at the channel's current source address. It is followed directly by one write beat (`mem_we`=1) at the current destination address, carrying the data just read. A write beat is never the first beat after an idle cycle.
- R3: Control bits [2:0] select the element size. Codes 0/1/2/3 move 1/2/4/8 bytes, and `mem_size` carries the byte count as its log2. Code 4 is mixed mode: the read is 1 byte and the write is 4 bytes, with the upper three bytes zero. No byte outside the element is written.
- R4: Registers are selected by `cfg_reg`: 0 source, 1 destination, 2 count [15:0] and threshold [31:16], 3 control, 4 steps (source step [15:0], destination step [31:16]), 5 start, 6 clear. After each element, the source and destination addresses advance by their own step, which may exceed the element size. A block moves exactly `count` elements.
- R5: Control bits [13:9] select the start condition. Value 0 means a write to register 5 starts the channel. Value k from 1 to 31 means a high level on `hw_req[k-1]` starts it. All other request lines are ignored.
- R6: When several channels are waiting, a channel with control bit [4] set is served first. Ties go to the lowest channel index.
- R7: A waiting channel of higher rank takes over the memory port at the next element boundary. There is always one idle cycle after each write beat. The displaced channel later resumes and completes its block with correct data.
- R8: `sts_early` sets when the remaining count after an element equals the threshold. A threshold written as 0 means half the count, rounded down. If the resulting threshold is 0, no early flag is raised.
- R9: `sts_done` sets when the last element is written. Both flags are sticky and clear only when register 6 is written with a 1 in bit 0 (done) or bit 1 (early). `irq_done`/`irq_early` are the OR of the respective flags.
- R10: A channel below index 3 with control bit [3] set reloads its starting addresses and count at the end of the block and stays enabled. Any other channel clears its enable (control bit [15]) at the end of the block, so later start requests have no effect.
- R11: With control bit [5] set, a channel also starts when the channel named in control bits [8:6] completes its block.
- R12: While `mem_valid` is high and `mem_ready` low, the address, size and write-enable stay stable. The transfer stays correct under any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_chan | input | 3 | Channel addressed by the write |
| cfg_reg | input | 3 | Register addressed within the channel |
| cfg_wdata | input | 32 | Register write data |
| hw_req | input | 31 | Hardware start request lines |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accepted |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_size | output | 2 | log2 of the beat size in bytes |
| mem_wdata | output | 64 | Write data, little-endian, low bytes valid |
| mem_rdata | input | 64 | Read data, valid while `mem_ready` is high on a read beat |
| sts_done | output | 7 | Sticky block-complete flags, one per channel |
| sts_early | output | 7 | Sticky early-point flags, one per channel |
| irq_done | output | 1 | Any completion flag set |
| irq_early | output | 1 | Any early flag set |

## Verification
A saved address or count that goes wrong inside a channel shows up at the next write beat of that channel. It appears either as a destination byte with the wrong value or position, or as a done flag that rises one element early or late. This is visible within one element time, seven cycles at two wait states. A wrong enable or reload after completion shows up as extra or missing write beats after the next start request. A wrong choice by the arbiter shows up directly in the order of destination addresses on the port. The bench therefore logs every write beat and compares both memory contents and beat order against values it computes from the register settings.

// File: rtl/dma_pkg.sv
// Shared constants, types and size helpers for the copy engine.
// Assumes a 32-bit address, a 64-bit data path and a 16-bit element count.
package dma_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 64;
    localparam int CNT_W    = 16;
    localparam int CH_IDX_W = 3;
    localparam int TSEL_W   = 5;
    localparam int HW_REQ_N = (2 ** TSEL_W) - 1;
    localparam int CASC_N   = 2 ** CH_IDX_W;

    localparam logic [2:0] REG_SRC   = 3'd0;
    localparam logic [2:0] REG_DST   = 3'd1;
    localparam logic [2:0] REG_CNT   = 3'd2;
    localparam logic [2:0] REG_CTRL  = 3'd3;
    localparam logic [2:0] REG_STEP  = 3'd4;
    localparam logic [2:0] REG_START = 3'd5;
    localparam logic [2:0] REG_CLR   = 3'd6;

    localparam logic [2:0] SZ_MIXED = 3'd4;

    typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

    typedef struct packed {
        logic                en;
        logic [TSEL_W-1:0]   tsel;
        logic [CH_IDX_W-1:0] casc_src;
        logic                casc_en;
        logic                hi;
        logic                rpt;
        logic [2:0]          size;
    } ctrl_t;

    // Read beat size (log2 bytes) for a size code.
    function automatic logic [1:0] rd_size(input logic [2:0] code);
        return (code == SZ_MIXED) ? 2'd0 : code[1:0];
    endfunction

    // Write beat size (log2 bytes) for a size code.
    function automatic logic [1:0] wr_size(input logic [2:0] code);
        return (code == SZ_MIXED) ? 2'd2 : code[1:0];
    endfunction

    // Mask that keeps the valid low bytes of a beat.
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return DATA_W'(64'hFF);
            2'd1:    return DATA_W'(64'hFFFF);
            2'd2:    return DATA_W'(64'hFFFF_FFFF);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/dma_arb.sv
// Picks the channel that runs the next element.
// Channels with the raise bit set beat all others; ties go to the lowest index.
// Purely combinational; the mover samples the result only at element boundaries.
module dma_arb #(
    parameter  int N  = 7,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  hi,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] pool;

    // Restrict to the raised class if any raised channel is waiting, then take the lowest index.
    always_comb begin
        pool = ((req & hi) != '0) ? (req & hi) : req;
        any  = (req != '0);
        idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_chan.sv
// One channel: register set, live address/count state, start logic and flags.
// Assumes software does not rewrite a channel while its element is on the port.
// FULL enables the repeat (reload) mode.
module dma_chan
    import dma_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_reg,
    input  logic [31:0]         wr_data,
    input  logic [HW_REQ_N:0]   req_ext,
    input  logic [CASC_N-1:0]   casc_done,
    input  logic                elem_done,
    output logic                want,
    output logic                hi,
    output logic [ADDR_W-1:0]   src,
    output logic [ADDR_W-1:0]   dst,
    output logic [2:0]          size,
    output logic                done_pulse,
    output logic                sts_done,
    output logic                sts_early
);
    ctrl_t              ctrl;
    logic [ADDR_W-1:0]  base_src, base_dst;
    logic [CNT_W-1:0]   base_cnt, cnt, thr;
    logic [15:0]        src_step, dst_step;
    logic               pend;
    logic               start_hit;

    // Start condition: selected request line or the cascade source's completion.
    assign start_hit = ctrl.en &&
                       (((ctrl.tsel != '0) && req_ext[ctrl.tsel]) ||
                        (ctrl.casc_en && casc_done[ctrl.casc_src]));

    assign want = pend && ctrl.en && (cnt != '0);
    assign hi   = ctrl.hi;
    assign size = ctrl.size;

    // Channel state: starts, element advance, block end, register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            base_src   <= '0;
            base_dst   <= '0;
            base_cnt   <= '0;
            src        <= '0;
            dst        <= '0;
            cnt        <= '0;
            thr        <= '0;
            src_step   <= '0;
            dst_step   <= '0;
            pend       <= 1'b0;
            done_pulse <= 1'b0;
            sts_done   <= 1'b0;
            sts_early  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (start_hit) pend <= 1'b1;
            if (elem_done) begin
                src <= src + ADDR_W'(src_step);
                dst <= dst + ADDR_W'(dst_step);
                cnt <= cnt - 1'b1;
                if ((thr != '0) && ((cnt - 1'b1) == thr)) sts_early <= 1'b1;
                if (cnt == CNT_W'(1)) begin
                    sts_done   <= 1'b1;
                    done_pulse <= 1'b1;
                    pend       <= 1'b0;
                    if (FULL && ctrl.rpt) begin
                        src <= base_src;
                        dst <= base_dst;
                        cnt <= base_cnt;
                    end else begin
                        ctrl.en <= 1'b0;
                    end
                end
            end
            if (wr_en) begin
                case (wr_reg)
                    REG_SRC: begin
                        base_src <= wr_data;
                        src      <= wr_data;
                    end
                    REG_DST: begin
                        base_dst <= wr_data;
                        dst      <= wr_data;
                    end
                    REG_CNT: begin
                        base_cnt <= wr_data[15:0];
                        cnt      <= wr_data[15:0];
                        thr      <= (wr_data[31:16] == '0) ? {1'b0, wr_data[15:1]} : wr_data[31:16];
                    end
                    REG_CTRL: begin
                        ctrl.size     <= wr_data[2:0];
                        ctrl.rpt      <= wr_data[3];
                        ctrl.hi       <= wr_data[4];
                        ctrl.casc_en  <= wr_data[5];
                        ctrl.casc_src <= wr_data[8:6];
                        ctrl.tsel     <= wr_data[13:9];
                        ctrl.en       <= wr_data[15];
                        pend          <= 1'b0;
                    end
                    REG_STEP: begin
                        src_step <= wr_data[15:0];
                        dst_step <= wr_data[31:16];
                    end
                    REG_START: if (ctrl.en && (ctrl.tsel == '0)) pend <= 1'b1;
                    REG_CLR: begin
                        if (wr_data[0]) sts_done  <= 1'b0;
                        if (wr_data[1]) sts_early <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_mover.sv
// Moves one element per grant: read beat, then write beat, then one idle cycle
// in which the next channel is chosen. Holds the read data in a single register.
// Assumes the chosen channel's address and size stay fixed during the element.
module dma_mover
    import dma_pkg::*;
#(
    parameter  int N  = 7,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [IW-1:0]     gnt_idx,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [2:0]        size,
    output logic [IW-1:0]     act_idx,
    output logic              elem_done,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    mv_state_e         state;
    logic [DATA_W-1:0] data_q;

    // Element sequencing and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MV_IDLE;
            act_idx <= '0;
            data_q  <= '0;
        end else begin
            case (state)
                MV_IDLE: if (any_req) begin
                    act_idx <= gnt_idx;
                    state   <= MV_READ;
                end
                MV_READ: if (mem_ready) begin
                    data_q <= mem_rdata & size_mask(rd_size(size));
                    state  <= MV_WRITE;
                end
                MV_WRITE: if (mem_ready) state <= MV_IDLE;
                default: state <= MV_IDLE;
            endcase
        end
    end

    // Memory port drive from the current phase.
    always_comb begin
        mem_valid = (state != MV_IDLE);
        mem_we    = (state == MV_WRITE);
        mem_addr  = mem_we ? dst : src;
        mem_size  = mem_we ? wr_size(size) : rd_size(size);
        mem_wdata = data_q;
        elem_done = mem_we && mem_ready;
    end
endmodule

// File: rtl/dma_engine.sv
// Top level: seven channels, the arbiter and the element mover.
// Channels below NFULL may repeat; the others stop after one block.
// Assumes NCH <= 2**CH_IDX_W and a single-beat memory that accepts one beat per handshake.
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH   = 7,
    parameter int NFULL = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CH_IDX_W-1:0] cfg_chan,
    input  logic [2:0]          cfg_reg,
    input  logic [31:0]         cfg_wdata,
    input  logic [HW_REQ_N-1:0] hw_req,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [NCH-1:0]      sts_done,
    output logic [NCH-1:0]      sts_early,
    output logic                irq_done,
    output logic                irq_early
);
    localparam int IW = $clog2(NCH);

    logic [NCH-1:0]    want, hi, done_p, elem_dn;
    logic [ADDR_W-1:0] src_a  [NCH];
    logic [ADDR_W-1:0] dst_a  [NCH];
    logic [2:0]        size_a [NCH];
    logic [HW_REQ_N:0] req_ext;
    logic [CASC_N-1:0] casc_vec;
    logic              any_req, elem_done;
    logic [IW-1:0]     gnt_idx, act_idx;

    assign req_ext   = {hw_req, 1'b0};
    assign casc_vec  = CASC_N'(done_p);
    assign irq_done  = |sts_done;
    assign irq_early = |sts_early;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_chan #(.FULL(i < NFULL)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_wr && (cfg_chan == CH_IDX_W'(i))),
            .wr_reg     (cfg_reg),
            .wr_data    (cfg_wdata),
            .req_ext    (req_ext),
            .casc_done  (casc_vec),
            .elem_done  (elem_dn[i]),
            .want       (want[i]),
            .hi         (hi[i]),
            .src        (src_a[i]),
            .dst        (dst_a[i]),
            .size       (size_a[i]),
            .done_pulse (done_p[i]),
            .sts_done   (sts_done[i]),
            .sts_early  (sts_early[i])
        );
        assign elem_dn[i] = elem_done && (act_idx == IW'(i));
    end

    dma_arb #(.N(NCH)) u_arb (
        .req (want),
        .hi  (hi),
        .any (any_req),
        .idx (gnt_idx)
    );

    dma_mover #(.N(NCH)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .gnt_idx   (gnt_idx),
        .src       (src_a[act_idx]),
        .dst       (dst_a[act_idx]),
        .size      (size_a[act_idx]),
        .act_idx   (act_idx),
        .elem_done (elem_done),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: rtl/dma_engine_chk.sv
// Port-level protocol and flag checks for dma_engine, attached with bind.
// Assumes the synchronous active-low reset of the engine.
module dma_engine_chk
    import dma_pkg::*;
#(
    parameter int NCH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [2:0]        cfg_reg,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [NCH-1:0]    sts_done,
    input logic [NCH-1:0]    sts_early
);
    // R12: a stalled beat keeps its address, size and direction.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we)));

    // R2: an accepted read is followed at once by the write of the same element.
    p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_we) |=> (mem_valid && mem_we));

    // R2: a write beat never opens an element.
    p_no_leading_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |=> !(mem_valid && mem_we));

    // R7: an idle cycle follows every write, where the next channel is chosen.
    p_boundary_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> !mem_valid);

    // R9: done flags fall only on a write to the clear register.
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && (cfg_reg == REG_CLR)) |=> (($past(sts_done) & ~sts_done) == '0));

    // R9: early flags fall only on a write to the clear register.
    p_early_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && (cfg_reg == REG_CLR)) |=> (($past(sts_early) & ~sts_early) == '0));
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;
    import dma_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_wr = 1'b0;
    logic [2:0]          cfg_chan = '0;
    logic [2:0]          cfg_reg = '0;
    logic [31:0]         cfg_wdata = '0;
    logic [HW_REQ_N-1:0] hw_req = '0;
    logic                mem_valid, mem_we, irq_done, irq_early;
    logic                mem_ready = 1'b0;
    logic [31:0]         mem_addr;
    logic [1:0]          mem_size;
    logic [63:0]         mem_wdata;
    logic [63:0]         mem_rdata = '0;
    logic [6:0]          sts_done, sts_early;

    int checks = 0;
    int fails  = 0;
    int wait_cyc = 0;
    int wcnt = 0;
    logic [7:0]  mem [1024];
    logic [31:0] log_a [1024];
    int nlog = 0;

    always #2.5 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .hw_req(hw_req), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sts_done(sts_done), .sts_early(sts_early),
        .irq_done(irq_done), .irq_early(irq_early)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic int chan_of(logic [31:0] a);
        return (int'(a) - 32'h200) >>> 6;
    endfunction

    function automatic int wr_of(int c);
        int n = 0;
        for (int i = 0; i < nlog; i++) if (chan_of(log_a[i]) == c) n++;
        return n;
    endfunction

    function automatic logic [31:0] ctl(int sz, int rpt, int hi, int ce, int cs, int sel);
        return 32'((1 << 15) | (sel << 9) | (cs << 6) | (ce << 5) | (hi << 4) | (rpt << 3) | sz);
    endfunction

    // Memory model: ready after wait_cyc cycles, read data presented away from the edge.
    always @(negedge clk) begin
        if (!mem_valid) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (wcnt >= wait_cyc) begin
            mem_ready = 1'b1;
            wcnt = 0;
            for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem[int'((mem_addr + 32'(k)) & 32'h3FF)];
        end else begin
            mem_ready = 1'b0;
            wcnt++;
        end
    end

    // Memory model: commit and log accepted write beats.
    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we) begin
            for (int k = 0; k < (1 << mem_size); k++) mem[int'((mem_addr + 32'(k)) & 32'h3FF)] = mem_wdata[8*k +: 8];
            if (nlog < 1024) log_a[nlog] = mem_addr;
            nlog++;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 1024; i++) mem[i] = (i < 512) ? pat(i) : 8'hEE;
    endtask

    task automatic wr(int ch, logic [2:0] rg, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_chan = 3'(ch); cfg_reg = rg; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic setup(int ch, int s, int d, logic [31:0] cntw, logic [31:0] steps, logic [31:0] c);
        wr(ch, REG_SRC, 32'(s));
        wr(ch, REG_DST, 32'(d));
        wr(ch, REG_CNT, cntw);
        wr(ch, REG_STEP, steps);
        wr(ch, REG_CTRL, c);
    endtask

    task automatic wait_done(int ch, string tag);
        int n = 0;
        while (!sts_done[ch] && n < 5000) begin @(negedge clk); n++; end
        check(tag, 64'(sts_done[ch]), 64'd1);
    endtask

    task automatic pulse_req(int line);
        @(negedge clk); hw_req[line] = 1'b1;
        @(negedge clk); hw_req[line] = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base, n0;
        init_mem();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 mem_valid", 64'(mem_valid), 0);
        check("R1 sts_done", 64'(sts_done), 0);
        check("R1 sts_early", 64'(sts_early), 0);
        check("R1 irq", 64'({irq_done, irq_early}), 0);

        // R2 R3 R12: all size codes, with and without wait states, on basic channel 3
        for (int w = 0; w <= 2; w += 2) begin
            wait_cyc = w;
            for (int s = 0; s <= 4; s++) begin
                int n, ss, ds;
                init_mem();
                wr(3, REG_CLR, 3);
                ss = (s == 4) ? 1 : (1 << s);
                ds = (s == 4) ? 4 : (1 << s);
                n  = (s == 4) ? 16 : (4 << s);
                setup(3, 0, 32'h2C0, 4, 32'((ds << 16) | ss), ctl(s, 0, 0, 0, 0, 0));
                wr(3, REG_START, 0);
                wait_done(3, "R9 done size sweep");
                for (int j = 0; j < n; j++)
                    check($sformatf("R3 size %0d wait %0d byte %0d", s, w, j), 64'(mem[32'h2C0 + j]),
                          64'((s == 4) ? ((j % 4 == 0) ? pat(j / 4) : 8'h00) : pat(j)));
                check("R3 no byte past element", 64'(mem[32'h2C0 + n]), 64'hEE);
                // R10: basic channel disabled after its block
                n0 = nlog;
                wr(3, REG_START, 0);
                repeat (20) @(negedge clk);
                check("R10 basic ignores restart", 64'(nlog), 64'(n0));
            end
        end
        wait_cyc = 0;

        // R4: stride addressing on channel 0
        init_mem();
        wr(0, REG_CLR, 3);
        setup(0, 0, 32'h200, 5, 32'h0001_0003, ctl(0, 0, 0, 0, 0, 0));
        wr(0, REG_START, 0);
        wait_done(0, "R4 done stride byte");
        for (int i = 0; i < 5; i++) check("R4 stride 3 byte", 64'(mem[32'h200 + i]), 64'(pat(3 * i)));
        check("R4 count exact", 64'(mem[32'h205]), 64'hEE);
        init_mem();
        wr(0, REG_CLR, 3);
        setup(0, 0, 32'h200, 4, 32'h0002_0006, ctl(1, 0, 0, 0, 0, 0));
        wr(0, REG_START, 0);
        wait_done(0, "R4 done stride half");
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 2; k++)
                check("R4 stride 6 half", 64'(mem[32'h200 + 2 * i + k]), 64'(pat(6 * i + k)));

        // R5: hardware start on the selected line only
        init_mem();
        setup(1, 0, 32'h240, 2, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 5));
        n0 = nlog;
        pulse_req(3);
        repeat (20) @(negedge clk);
        check("R5 other line ignored", 64'(nlog), 64'(n0));
        check("R5 no done on other line", 64'(sts_done[1]), 0);
        pulse_req(4);
        wait_done(1, "R5 done on selected line");
        check("R5 data 0", 64'(mem[32'h240]), 64'(pat(0)));
        check("R5 data 1", 64'(mem[32'h241]), 64'(pat(1)));

        // R8: early flag at default half and at an explicit threshold
        wait_cyc = 2;
        init_mem();
        wr(2, REG_CLR, 3);
        setup(2, 0, 32'h280, 8, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 0));
        base = wr_of(2);
        wr(2, REG_START, 0);
        while (!sts_early[2]) @(negedge clk);
        check("R8 early at half", 64'(wr_of(2) - base), 4);
        check("R9 irq_early", 64'(irq_early), 1);
        wait_done(2, "R8 done");
        check("R9 early stays", 64'(sts_early[2]), 1);
        wr(2, REG_CLR, 1);
        check("R9 done cleared", 64'(sts_done[2]), 0);
        check("R9 early kept", 64'(sts_early[2]), 1);
        wr(2, REG_CLR, 2);
        check("R9 early cleared", 64'(sts_early[2]), 0);
        setup(2, 0, 32'h280, 32'h0006_0008, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 0));
        base = wr_of(2);
        wr(2, REG_START, 0);
        while (!sts_early[2]) @(negedge clk);
        check("R8 early at threshold 6", 64'(wr_of(2) - base), 2);
        wait_done(2, "R8 done thr");
        wr(2, REG_CLR, 3);
        setup(2, 0, 32'h280, 1, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 0));
        wr(2, REG_START, 0);
        wait_done(2, "R8 done count 1");
        check("R8 no early for count 1", 64'(sts_early[2]), 0);
        wr(2, REG_CLR, 3);
        wait_cyc = 0;

        // R10: repeat mode reloads and stays enabled on channel 0
        init_mem();
        wr(0, REG_CLR, 3);
        setup(0, 0, 32'h200, 2, 32'h0001_0001, ctl(0, 1, 0, 0, 0, 0));
        wr(0, REG_START, 0);
        wait_done(0, "R10 first block");
        mem[32'h200] = 8'hEE; mem[32'h201] = 8'hEE;
        wr(0, REG_CLR, 3);
        wr(0, REG_START, 0);
        wait_done(0, "R10 second block");
        check("R10 reload byte 0", 64'(mem[32'h200]), 64'(pat(0)));
        check("R10 reload byte 1", 64'(mem[32'h201]), 64'(pat(1)));
        check("R10 no continuation", 64'(mem[32'h202]), 64'hEE);

        // R6: rank by index, then raise bit overrides index
        for (int h = 0; h <= 1; h++) begin
            wr(4, REG_CLR, 3); wr(5, REG_CLR, 3);
            setup(4, 0, 32'h300, 2, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 3));
            setup(5, 0, 32'h340, 2, 32'h0001_0001, ctl(0, 0, h, 0, 0, 3));
            n0 = nlog;
            pulse_req(2);
            wait_done(4, "R6 ch4 done");
            wait_done(5, "R6 ch5 done");
            check($sformatf("R6 first winner raise=%0d", h), 64'(chan_of(log_a[n0])), 64'(h ? 5 : 4));
            check($sformatf("R6 second beat raise=%0d", h), 64'(chan_of(log_a[n0 + 1])), 64'(h ? 5 : 4));
        end

        // R7: channel 3 takes over from running channel 6, which then resumes
        wait_cyc = 2;
        init_mem();
        wr(3, REG_CLR, 3); wr(6, REG_CLR, 3);
        setup(6, 0, 32'h380, 10, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 0));
        base = wr_of(6);
        wr(6, REG_START, 0);
        while (wr_of(6) - base < 2) @(negedge clk);
        setup(3, 32'h100, 32'h2C0, 2, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 0));
        wr(3, REG_START, 0);
        wait_done(3, "R7 preempting done");
        wait_done(6, "R7 resumed done");
        check("R7 resumed channel finishes last", 64'(chan_of(log_a[nlog - 1])), 6);
        check("R7 resumed element count", 64'(wr_of(6) - base), 10);
        for (int i = 0; i < 10; i++) check("R7 resumed data", 64'(mem[32'h380 + i]), 64'(pat(i)));
        check("R7 preempting data", 64'(mem[32'h2C1]), 64'(pat(32'h101)));
        wait_cyc = 0;

        // R11: channel 1 follows the completion of channel 2
        init_mem();
        wr(1, REG_CLR, 3); wr(2, REG_CLR, 3);
        setup(1, 32'h20, 32'h240, 3, 32'h0001_0001, ctl(0, 0, 0, 1, 2, 31));
        setup(2, 0, 32'h280, 2, 32'h0001_0001, ctl(0, 0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        check("R11 idle before source ends", 64'(sts_done[1]), 0);
        wr(2, REG_START, 0);
        wait_done(2, "R11 source done");
        wait_done(1, "R11 follower done");
        for (int i = 0; i < 3; i++) check("R11 follower data", 64'(mem[32'h240 + i]), 64'(pat(32'h20 + i)));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule